// File: doc/BRIEF.md
# Bilateral Idle Entry Handshake Controller

This block sits in the downstream port of a serial link and negotiates moving both link directions into a deep idle state together. A request to enter can come from two places: an inactivity detector, which asks for an autonomous entry, or a device power-state change to a low-power state, which demands entry. Either source sends a request packet toward the upstream partner and then waits for a reply. An accept makes the block transmit an electrical-idle ordered set and park in the idle state. A reject, which only an autonomous request may receive, sends the block to the light single-direction standby state when that is enabled, and to full operation when it is not. If no reply arrives within a bounded window, the block gives up, returns to full operation and raises an error flag.

Leaving the deep idle state needs no negotiation. A local wake or a detected exit from electrical idle on the receive side makes the block send a training-set strobe. The block then walks a fixed three-step recovery chain (receiver lock, receiver configuration, recovery idle) before returning to full operation. Packet framing, checksums and training-set contents live elsewhere. Here they appear as single-cycle strobes that carry small type codes.

Top module: `idle_hs_top`

## Requirements
- R1: After reset, linkState is 0 (active), txValid is 0 and replyTimeoutErr is 0.
- R2: In state 0, a pulse on inactiveReq causes txValid=1 with txCode=1 (autonomous request) in the next cycle, and linkState becomes 1 (awaiting reply).
- R3: In state 0, a pulse on pwrDownReq causes txValid=1 with txCode=2 (power-state request) in the next cycle, and linkState becomes 1. If both requests arrive in the same cycle, the power-state request wins.
- R4: In state 1, rxValid with rxCode=1 (accept) causes txValid=1 with txCode=3 (electrical-idle ordered set) in the next cycle, and linkState becomes 2 (deep idle).
- R5: In state 1 with an autonomous request pending, rxValid with rxCode=2 (reject) moves linkState to 6 (light standby) if standbyEn is 1 and to 0 if it is 0, with no transmit strobe.
- R6: In state 1 with a power-state request pending, a reject (rxCode=2) is ignored: linkState stays 1 and nothing is transmitted.
- R7: If no accept or qualifying reject arrives during TIMEOUT_CYC cycles in state 1, linkState returns to 0 and replyTimeoutErr becomes 1. The flag stays set until the next request is launched, and is cleared in the same cycle that request's strobe appears.
- R8: A request of either kind is ignored in every state other than 0. linkState is unchanged and txValid stays 0.
- R9: In state 2, wakeLocal or wakeRemote causes txValid=1 with txCode=4 (training set) in the next cycle, and linkState becomes 3 (receiver lock).
- R10: Recovery advances only on recStep, in the order 3 (receiver lock), 4 (receiver config), 5 (recovery idle), 0. Without recStep the state holds.
- R11: A reply (rxValid) outside state 1, or one whose rxCode is 0 or 3, has no effect.
- R12: In state 6, wakeLocal returns linkState to 0 without a transmit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inactiveReq | input | 1 | Inactivity strobe requesting autonomous entry |
| pwrDownReq | input | 1 | Device power-state change strobe demanding entry |
| standbyEn | input | 1 | Light standby state enabled |
| rxValid | input | 1 | Reply packet received strobe |
| rxCode | input | 2 | Reply type: 1 accept, 2 reject |
| wakeLocal | input | 1 | Local side needs the link |
| wakeRemote | input | 1 | Partner left electrical idle |
| recStep | input | 1 | Current recovery substate complete |
| txValid | output | 1 | Transmit strobe |
| txCode | output | 3 | 1 autonomous req, 2 power-state req, 3 idle ordered set, 4 training set |
| linkState | output | 3 | 0 active, 1 await reply, 2 deep idle, 3/4/5 recovery, 6 standby |
| replyTimeoutErr | output | 1 | Reply window expired |

## Verification
The bench targets a reject that arrives while a power-state request is pending. A design that honoured it would leave state 1 early, even though that request must be accepted. It counts the timeout window down to the exact cycle, so an off-by-one window or a flag that never clears shows up as a state or flag mismatch. It also drives requests in standby, idle and recovery, and replies outside the wait state, where a careless design would send a second request or jump straight from standby to deep idle. A long random run compares every cycle against a reference model, which also catches recovery steps taken in the wrong order.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_WAIT    = 3'd1,
    ST_IDLE    = 3'd2,
    ST_RLOCK   = 3'd3,
    ST_RCFG    = 3'd4,
    ST_RIDLE   = 3'd5,
    ST_STANDBY = 3'd6
  } linkSt_e;

  localparam logic [1:0] RX_ACCEPT = 2'd1;
  localparam logic [1:0] RX_REJECT = 2'd2;

  localparam logic [2:0] TX_NONE     = 3'd0;
  localparam logic [2:0] TX_AUTO_REQ = 3'd1;
  localparam logic [2:0] TX_PM_REQ   = 3'd2;
  localparam logic [2:0] TX_EIOS     = 3'd3;
  localparam logic [2:0] TX_TS1      = 3'd4;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic sendAuto;
    logic sendPm;
    logic sendEios;
    logic sendTs1;
    logic timerClr;
    logic timerRun;
    logic raiseErr;
  } hsStrobe_t;

endpackage

// File: rtl/idle_hs_ctrl.sv
module idle_hs_ctrl
  import idle_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inactiveReq,
  input  logic       pwrDownReq,
  input  logic       standbyEn,
  input  logic       rxValid,
  input  logic [1:0] rxCode,
  input  logic       wakeLocal,
  input  logic       wakeRemote,
  input  logic       recStep,
  input  logic       timerExpire,
  output hsStrobe_t  stb,
  output linkSt_e    stateQ
);

  linkSt_e stateD;
  logic    pendPmQ;
  logic    gotAccept;
  logic    gotReject;

  assign gotAccept = rxValid && (rxCode == RX_ACCEPT);
  assign gotReject = rxValid && (rxCode == RX_REJECT);

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_ACTIVE: begin
        if (pwrDownReq) begin
          stb.sendPm   = 1'b1;
          stb.timerClr = 1'b1;
          stateD       = ST_WAIT;
        end else if (inactiveReq) begin
          stb.sendAuto = 1'b1;
          stb.timerClr = 1'b1;
          stateD       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        stb.timerRun = 1'b1;
        if (gotAccept) begin
          stb.sendEios = 1'b1;
          stateD       = ST_IDLE;
        end else if (gotReject && !pendPmQ) begin
          stateD = standbyEn ? ST_STANDBY : ST_ACTIVE;
        end else if (timerExpire) begin
          stb.raiseErr = 1'b1;
          stateD       = ST_ACTIVE;
        end
      end
      ST_IDLE: begin
        if (wakeLocal || wakeRemote) begin
          stb.sendTs1 = 1'b1;
          stateD      = ST_RLOCK;
        end
      end
      ST_RLOCK:   if (recStep) stateD = ST_RCFG;
      ST_RCFG:    if (recStep) stateD = ST_RIDLE;
      ST_RIDLE:   if (recStep) stateD = ST_ACTIVE;
      ST_STANDBY: if (wakeLocal) stateD = ST_ACTIVE;
      default:    stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_ACTIVE;
      pendPmQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stb.sendPm || stb.sendAuto) pendPmQ <= stb.sendPm;
    end
  end

  AST_PM_REJECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_WAIT && pendPmQ && gotReject && !timerExpire) |=> (stateQ == ST_WAIT)); // R6

  AST_TIMEOUT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_WAIT && timerExpire && !rxValid) |=> (stateQ == ST_ACTIVE)); // R7

  AST_RECOVERY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_RCFG) |-> ($past(stateQ) == ST_RLOCK || $past(stateQ) == ST_RCFG)); // R10

  AST_STANDBY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_STANDBY) |=> (stateQ == ST_STANDBY || stateQ == ST_ACTIVE)); // R8

endmodule

// File: rtl/idle_hs_datapath.sv
module idle_hs_datapath
  import idle_hs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  hsStrobe_t  stb,
  output logic       timerExpire,
  output logic       txValid,
  output logic [2:0] txCode,
  output logic       timeoutErr
);

  localparam int TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] timerQ;
  logic [2:0]    codeD;

  always_comb begin
    codeD = TX_NONE;
    if (stb.sendPm)        codeD = TX_PM_REQ;
    else if (stb.sendAuto) codeD = TX_AUTO_REQ;
    else if (stb.sendEios) codeD = TX_EIOS;
    else if (stb.sendTs1)  codeD = TX_TS1;
  end

  assign timerExpire = (timerQ == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerQ     <= '0;
      txValid    <= 1'b0;
      txCode     <= TX_NONE;
      timeoutErr <= 1'b0;
    end else begin
      if (stb.timerClr)      timerQ <= '0;
      else if (stb.timerRun) timerQ <= timerQ + 1'b1;
      txValid <= (codeD != TX_NONE);
      txCode  <= codeD;
      if (stb.sendPm || stb.sendAuto) timeoutErr <= 1'b0;
      else if (stb.raiseErr)          timeoutErr <= 1'b1;
    end
  end

  AST_TX_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> (txCode != TX_NONE)); // R2

  AST_ERR_CLEARS_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && (txCode == TX_AUTO_REQ || txCode == TX_PM_REQ)) |-> !timeoutErr); // R7

endmodule

// File: rtl/idle_hs_top.sv
module idle_hs_top
  import idle_hs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inactiveReq,
  input  logic       pwrDownReq,
  input  logic       standbyEn,
  input  logic       rxValid,
  input  logic [1:0] rxCode,
  input  logic       wakeLocal,
  input  logic       wakeRemote,
  input  logic       recStep,
  output logic       txValid,
  output logic [2:0] txCode,
  output logic [2:0] linkState,
  output logic       replyTimeoutErr
);

  hsStrobe_t stb;
  linkSt_e   stateQ;
  logic      timerExpire;

  idle_hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .inactiveReq(inactiveReq), .pwrDownReq(pwrDownReq), .standbyEn(standbyEn),
    .rxValid(rxValid), .rxCode(rxCode),
    .wakeLocal(wakeLocal), .wakeRemote(wakeRemote), .recStep(recStep),
    .timerExpire(timerExpire), .stb(stb), .stateQ(stateQ)
  );

  idle_hs_datapath #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .timerExpire(timerExpire),
    .txValid(txValid), .txCode(txCode), .timeoutErr(replyTimeoutErr)
  );

  assign linkState = stateQ;

  AST_ACCEPT_SENDS_EIOS: assert property (@(posedge clk) disable iff (!rst_n)
    (linkState == 3'd1 && rxValid && rxCode == 2'd1) |=> (txValid && txCode == 3'd3 && linkState == 3'd2)); // R4

  AST_WAKE_SENDS_TS1: assert property (@(posedge clk) disable iff (!rst_n)
    (linkState == 3'd2 && (wakeLocal || wakeRemote)) |=> (txValid && txCode == 3'd4 && linkState == 3'd3)); // R9

  AST_SILENT_RETURN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(linkState) == 3'd1 && linkState == 3'd0 && !$past(rxValid)) |-> replyTimeoutErr); // R7

  AST_REQ_IGNORED_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (linkState == 3'd1 && !rxValid) |=> !txValid); // R8

endmodule

// File: tb/idle_hs_top_test.sv
module idle_hs_top_test;

  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ia = 0, pd = 0, sb = 0, rv = 0, wl = 0, wr = 0, rs = 0;
  logic [1:0] rc = 0;
  logic       txValid, replyTimeoutErr;
  logic [2:0] txCode, linkState;

  int checks = 0;
  int fails  = 0;

  int   mState;
  logic mPm;
  int   mTimer;
  logic mErr;

  always #10 clk = ~clk;

  idle_hs_top #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .inactiveReq(ia), .pwrDownReq(pd), .standbyEn(sb),
    .rxValid(rv), .rxCode(rc), .wakeLocal(wl), .wakeRemote(wr), .recStep(rs),
    .txValid(txValid), .txCode(txCode), .linkState(linkState),
    .replyTimeoutErr(replyTimeoutErr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn();
    ia = 0; pd = 0; rv = 0; rc = 0; wl = 0; wr = 0; rs = 0;
  endtask

  task automatic check(string req, int expSt, logic expV, logic [2:0] expC, logic expE);
    checks++;
    if (linkState != 3'(expSt) || txValid != expV || (expV && txCode != expC) ||
        replyTimeoutErr != expE) begin
      fails++;
      $display("FAIL %s: state=%0d txValid=%0d txCode=%0d err=%0d expected state=%0d txValid=%0d txCode=%0d err=%0d",
               req, linkState, txValid, txCode, replyTimeoutErr, expSt, expV, expC, expE);
    end
  endtask

  // reference model: advance one cycle from the current inputs
  function automatic logic [3:0] modelStep();
    logic [3:0] tx;
    tx = 4'h0;
    case (mState)
      0: if (pd) begin tx = 4'b1010; mState = 1; mPm = 1; mTimer = 0; mErr = 0; end
         else if (ia) begin tx = 4'b1001; mState = 1; mPm = 0; mTimer = 0; mErr = 0; end
      1: begin
        if (rv && rc == 2'd1) begin tx = 4'b1011; mState = 2; end
        else if (rv && rc == 2'd2 && !mPm) mState = sb ? 6 : 0;
        else if (mTimer == T - 1) begin mState = 0; mErr = 1; end
        else mTimer++;
      end
      2: if (wl || wr) begin tx = 4'b1100; mState = 3; end
      3: if (rs) mState = 4;
      4: if (rs) mState = 5;
      5: if (rs) mState = 0;
      6: if (wl) mState = 0;
      default: mState = 0;
    endcase
    return tx;
  endfunction

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] expTx;
    void'($urandom(32'h1d1e5eed));
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    tick();
    check("R1", 0, 0, 0, 0);

    // autonomous request, then ignored request, then accept
    ia = 1; tick(); clearIn();
    check("R2", 1, 1, 3'd1, 0);
    pd = 1; ia = 1; tick(); clearIn();
    check("R8", 1, 0, 0, 0);
    rv = 1; rc = 2'd1; tick(); clearIn();
    check("R4", 2, 1, 3'd3, 0);
    rv = 1; rc = 2'd1; ia = 1; tick(); clearIn();
    check("R11", 2, 0, 0, 0);
    wr = 1; tick(); clearIn();
    check("R9", 3, 1, 3'd4, 0);
    pd = 1; tick(); clearIn();
    check("R10", 3, 0, 0, 0);
    rs = 1; tick(); check("R10", 4, 0, 0, 0);
    tick();         check("R10", 5, 0, 0, 0);
    tick();         check("R10", 0, 0, 0, 0);
    clearIn();

    // both requests: power-state wins; reject ignored; timeout
    ia = 1; pd = 1; tick(); clearIn();
    check("R3", 1, 1, 3'd2, 0);
    rv = 1; rc = 2'd2; sb = 1; tick(); clearIn();
    check("R6", 1, 0, 0, 0);
    rv = 1; rc = 2'd3; tick(); clearIn();
    check("R11", 1, 0, 0, 0);
    repeat (T - 3) tick();
    check("R7", 1, 0, 0, 0);
    tick();
    check("R7", 0, 0, 0, 1);
    tick();
    check("R7", 0, 0, 0, 1);
    ia = 1; tick(); clearIn();
    check("R7", 1, 1, 3'd1, 0);

    // reject to standby, requests ignored there, wake out
    rv = 1; rc = 2'd2; sb = 1; tick(); clearIn();
    check("R5", 6, 0, 0, 0);
    ia = 1; pd = 1; tick(); clearIn();
    check("R8", 6, 0, 0, 0);
    wr = 1; tick(); clearIn();
    check("R12", 6, 0, 0, 0);
    wl = 1; tick(); clearIn();
    check("R12", 0, 0, 0, 0);
    ia = 1; tick(); clearIn();
    check("R2", 1, 1, 3'd1, 0);
    rv = 1; rc = 2'd2; sb = 0; tick(); clearIn();
    check("R5", 0, 0, 0, 0);
    wl = 1; tick(); clearIn();
    check("R9", 0, 0, 0, 0);

    // random phase against the model
    mState = 0; mPm = 0; mTimer = 0; mErr = 0;
    for (int i = 0; i < 4000; i++) begin
      ia = ($urandom % 4) == 0;
      pd = ($urandom % 8) == 0;
      sb = $urandom % 2;
      rv = ($urandom % 10) == 0;
      rc = 2'($urandom % 4);
      wl = ($urandom % 6) == 0;
      wr = ($urandom % 6) == 0;
      rs = ($urandom % 3) == 0;
      expTx = modelStep();
      tick();
      check("R2..R12 model", mState, expTx[3], expTx[2:0], mErr);
    end
    clearIn();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule